// File: doc/BRIEF.md
# Banked Persistent Register File with Timed Commit

This block is the storage side of a digitally set potentiometer. It keeps sixteen 8-bit persistent registers, arranged as four banks of four, and serves the command decoder that sits in front of it. The decoder raises a write request for a bank and register, or a transfer request that copies the current wiper value into one of the four bank-0 registers. A request is only staged. It is committed when the decoder signals the end of the frame, which is the rising edge of chip select.

A commit starts a modelled slow programming cycle. The cycle length is a parameter counted in system clocks: at 125 MHz the default is about 5 ms, and a bench uses a short value. An in-progress flag stays high for the whole cycle and is also presented as a status byte. The new value lands in the register array on the clock edge that ends the cycle. While the cycle runs, reads still return the old content and new write or transfer requests are dropped. A low write-protect input blocks every persistent write.

Persistence is modelled by a separate power-on clear. The soft reset aborts a staged request or a running cycle, but it leaves the register contents as they are.

Top module: `persist_bank_file`

## Requirements
- R1: After power-on clear, all sixteen registers read 0x00, `busy` is 0 and `status` is 0x00.
- R2: A committed write to bank b, register r changes only the register at flat index {b, r}, which is read back through `rd_bank`/`rd_reg`. The other fifteen registers keep their values.
- R3: A request is held until `frame_end`. Without `frame_end`, `busy` stays 0 and no register changes. A later `frame_end` commits the staged request.
- R4: `busy` rises on the clock edge that samples `frame_end` with a staged request. It stays high for exactly PROG_CYCLES clock cycles.
- R5: `status` equals {7'b0, busy}, so the in-progress flag is bit 0.
- R6: If `wp_n` is 0 when a write or transfer request arrives, the request is dropped. A following `frame_end` then starts no cycle and changes nothing.
- R7: Write or transfer requests that arrive while `busy` is 1 are dropped. They never reach the array.
- R8: A transfer request writes `wiper_val` into bank 0 at register `xfer_reg`. Banks 1 to 3 are never the target of a transfer.
- R9: A soft reset (`rst_n` low) clears `busy` and any staged request. The register contents are kept.
- R10: While `busy` is 1, a read of the target register returns its old value. The new value appears on the edge where `busy` falls.
- R11: If a write request and a transfer request arrive in the same cycle, the write request is staged and the transfer is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on clear, active low; clears the registers too |
| rst_n | input | 1 | Soft reset, active low; keeps register contents |
| frame_end | input | 1 | One-cycle pulse at chip-select rising edge |
| wp_n | input | 1 | Write protect, low blocks persistent writes |
| wr_req | input | 1 | Direct write request pulse |
| wr_bank | input | 2 | Bank of the write |
| wr_reg | input | 2 | Register within the bank |
| wr_data | input | 8 | Data of the write |
| xfer_req | input | 1 | Wiper-to-register transfer request pulse |
| xfer_reg | input | 2 | Bank-0 register that receives the wiper value |
| wiper_val | input | 8 | Current wiper position |
| rd_bank | input | 2 | Bank of the read port |
| rd_reg | input | 2 | Register of the read port |
| rd_data | output | 8 | Combinational read of the selected register |
| busy | output | 1 | Programming cycle in progress |
| status | output | 8 | Status byte, in-progress flag in bit 0 |

## Verification
The bench writes every one of the sixteen locations in turn. After each commit it rereads all sixteen, so a bank/register decode that aliases or swaps bits shows up as corruption of a neighbour. It counts the cycles for which `busy` is high, which catches a timer that is off by one in either direction. During each cycle it reads the target register, which catches an array that updates at commit start instead of cycle end.

Further cases cover protection, busy-time requests, soft reset and same-cycle priority:
- a request made under write protect;
- a request issued mid-cycle;
- a soft reset issued mid-cycle;
- a request that is never followed by a frame end;
- write and transfer requests in the same cycle.

A design that ignored any of these rules would show a spurious busy period or a register changed against the bench's model.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
    localparam int unsigned PBF_DW    = 8;
    localparam int unsigned PBF_BANKS = 4;
    localparam int unsigned PBF_REGS  = 4;
    localparam int unsigned PBF_BSW   = $clog2(PBF_BANKS);
    localparam int unsigned PBF_RSW   = $clog2(PBF_REGS);
    localparam int unsigned PBF_AW    = PBF_BSW + PBF_RSW;

    typedef struct packed {
        logic              pend;
        logic [PBF_AW-1:0] addr;
        logic [PBF_DW-1:0] data;
    } pbf_stage_t;
endpackage

// File: rtl/pbf_commit_timer.sv
module pbf_commit_timer #(
    parameter int unsigned PROG_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic commit_o
);
    localparam int unsigned CW = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(PROG_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o   = tmr_q.busy;
    assign commit_o = tmr_q.busy && (tmr_q.cnt == '0);

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(tmr_q.cnt) < int'(PROG_CYCLES))); // R4
    AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !commit_o) |=> busy_o); // R4
endmodule

// File: rtl/pbf_req_stage.sv
module pbf_req_stage
    import pbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end_i,
    input  logic              wp_n_i,
    input  logic              busy_i,
    input  logic              wr_req_i,
    input  logic [PBF_AW-1:0] wr_addr_i,
    input  logic [PBF_DW-1:0] wr_data_i,
    input  logic              xf_req_i,
    input  logic [PBF_AW-1:0] xf_addr_i,
    input  logic [PBF_DW-1:0] xf_data_i,
    output logic              start_o,
    output logic [PBF_AW-1:0] stage_addr_o,
    output logic [PBF_DW-1:0] stage_data_o
);
    pbf_stage_t stg_d, stg_q;
    logic       accept;

    assign accept  = (wr_req_i || xf_req_i) && wp_n_i && !busy_i && !frame_end_i;
    assign start_o = frame_end_i && stg_q.pend && !busy_i;

    always_comb begin
        stg_d = stg_q;
        if (frame_end_i) begin
            stg_d.pend = 1'b0;
        end else if (accept) begin
            stg_d.pend = 1'b1;
            if (wr_req_i) begin
                stg_d.addr = wr_addr_i;
                stg_d.data = wr_data_i;
            end else begin
                stg_d.addr = xf_addr_i;
                stg_d.data = xf_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign stage_addr_o = stg_q.addr;
    assign stage_data_o = stg_q.data;

    AST_WP_BLOCKS_STAGING: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n_i && !stg_q.pend) |=> !stg_q.pend); // R6
    AST_BUSY_BLOCKS_STAGING: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !stg_q.pend) |=> !stg_q.pend); // R7
    AST_FRAME_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_i |=> !stg_q.pend); // R3
endmodule

// File: rtl/pbf_store.sv
module pbf_store #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_comb begin
            mem_d[g] = mem_q[g];
            if (we_i && (waddr_i == AW'(g))) mem_d[g] = wdata_i;
        end

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/persist_bank_file.sv
module persist_bank_file
    import pbf_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 625000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic              wp_n,
    input  logic              wr_req,
    input  logic [PBF_BSW-1:0] wr_bank,
    input  logic [PBF_RSW-1:0] wr_reg,
    input  logic [PBF_DW-1:0] wr_data,
    input  logic              xfer_req,
    input  logic [PBF_RSW-1:0] xfer_reg,
    input  logic [PBF_DW-1:0] wiper_val,
    input  logic [PBF_BSW-1:0] rd_bank,
    input  logic [PBF_RSW-1:0] rd_reg,
    output logic [PBF_DW-1:0] rd_data,
    output logic              busy,
    output logic [PBF_DW-1:0] status
);
    localparam int unsigned DEPTH = PBF_BANKS * PBF_REGS;

    logic              ctl_rst_n;
    logic              start;
    logic              commit;
    logic [PBF_AW-1:0] stage_addr;
    logic [PBF_DW-1:0] stage_data;

    assign ctl_rst_n = rst_n && por_n;

    pbf_req_stage u_stage (
        .clk          (clk),
        .rst_n        (ctl_rst_n),
        .frame_end_i  (frame_end),
        .wp_n_i       (wp_n),
        .busy_i       (busy),
        .wr_req_i     (wr_req),
        .wr_addr_i    ({wr_bank, wr_reg}),
        .wr_data_i    (wr_data),
        .xf_req_i     (xfer_req),
        .xf_addr_i    ({PBF_BSW'(0), xfer_reg}),
        .xf_data_i    (wiper_val),
        .start_o      (start),
        .stage_addr_o (stage_addr),
        .stage_data_o (stage_data)
    );

    pbf_commit_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (ctl_rst_n),
        .start_i  (start),
        .busy_o   (busy),
        .commit_o (commit)
    );

    pbf_store #(.DW(PBF_DW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .por_n   (por_n),
        .we_i    (commit),
        .waddr_i (stage_addr),
        .wdata_i (stage_data),
        .raddr_i ({rd_bank, rd_reg}),
        .rdata_o (rd_data)
    );

    assign status = {{(PBF_DW-1){1'b0}}, busy};

    AST_BUSY_NEEDS_FRAME_END: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        $rose(busy) |-> $past(frame_end)); // R3
    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        (busy && $past(busy) && $stable(rd_bank) && $stable(rd_reg)) |-> $stable(rd_data)); // R10
    AST_FROZEN_WHILE_IDLE: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        (!busy && !$past(busy) && $stable(rd_bank) && $stable(rd_reg)) |-> $stable(rd_data)); // R2
    AST_STATUS_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        $fell(busy) |-> (status == '0)); // R5
endmodule

// File: tb/test_persist_bank_file.sv
module test_persist_bank_file;
    localparam int PROG = 6;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       frame_end = 1'b0, wp_n = 1'b1;
    logic       wr_req = 1'b0, xfer_req = 1'b0;
    logic [1:0] wr_bank = '0, wr_reg = '0, xfer_reg = '0, rd_bank = '0, rd_reg = '0;
    logic [7:0] wr_data = '0, wiper_val = '0;
    logic [7:0] rd_data, status;
    logic       busy;

    int tests = 0, fails = 0;
    logic [7:0] mdl [16];

    always #4 clk = ~clk;

    persist_bank_file #(.PROG_CYCLES(PROG)) i_persist_bank_file (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .frame_end(frame_end), .wp_n(wp_n),
        .wr_req(wr_req), .wr_bank(wr_bank), .wr_reg(wr_reg), .wr_data(wr_data),
        .xfer_req(xfer_req), .xfer_reg(xfer_reg), .wiper_val(wiper_val),
        .rd_bank(rd_bank), .rd_reg(rd_reg), .rd_data(rd_data), .busy(busy), .status(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int idx, output logic [7:0] v);
        rd_bank = 2'(idx >> 2);
        rd_reg  = 2'(idx & 3);
        #1 v = rd_data;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        for (int i = 0; i < 16; i++) begin
            rd(i, v);
            chk(v == mdl[i], req, v, mdl[i]);
        end
    endtask

    task automatic stage_write(input int idx, input logic [7:0] d);
        @(negedge clk);
        wr_req = 1'b1; wr_bank = 2'(idx >> 2); wr_reg = 2'(idx & 3); wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic end_frame;
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 4 * PROG) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_all("R1");
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(status == 8'h00, "R1 status", status, 0);

        // R2 R4 R5 R10 sweep over every location
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d;
            d = 8'((i * 37 + 11) ^ 8'hA5);
            stage_write(i, d);
            end_frame();
            rd(i, v);
            chk(v == mdl[i], "R10 old value during cycle", v, mdl[i]);
            chk(status == 8'h01, "R5 status while busy", status, 1);
            count_busy(n);
            chk(n == PROG, "R4 busy length", n, PROG);
            chk(status == 8'h00, "R5 status after cycle", status, 0);
            mdl[i] = d;
            check_all("R2");
        end

        // R3 no frame_end, no commit
        stage_write(5, 8'h3C);
        repeat (PROG + 3) begin
            chk(busy == 1'b0, "R3 no busy without frame_end", busy, 0);
            @(negedge clk);
        end
        check_all("R3 unchanged");
        end_frame();
        count_busy(n);
        chk(n == PROG, "R3 late frame_end commits", n, PROG);
        mdl[5] = 8'h3C;
        check_all("R3 committed");

        // R6 write protect
        wp_n = 1'b0;
        stage_write(9, 8'h77);
        end_frame();
        chk(busy == 1'b0, "R6 no cycle under protect", busy, 0);
        @(negedge clk);
        xfer_req = 1'b1; xfer_reg = 2'd2; wiper_val = 8'h99;
        @(negedge clk);
        xfer_req = 1'b0;
        end_frame();
        chk(busy == 1'b0, "R6 no transfer under protect", busy, 0);
        wp_n = 1'b1;
        repeat (PROG + 2) @(negedge clk);
        check_all("R6 unchanged");

        // R7 requests during cycle dropped
        stage_write(12, 8'h5A);
        end_frame();
        wr_req = 1'b1; wr_bank = 2'd1; wr_reg = 2'd1; wr_data = 8'hEE;
        @(negedge clk);
        wr_req = 1'b0;
        xfer_req = 1'b1; xfer_reg = 2'd3; wiper_val = 8'hDD;
        @(negedge clk);
        xfer_req = 1'b0;
        count_busy(n);
        mdl[12] = 8'h5A;
        end_frame();
        chk(busy == 1'b0, "R7 dropped request starts no cycle", busy, 0);
        repeat (PROG + 2) @(negedge clk);
        check_all("R7");

        // R8 transfers into bank 0, every register
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            xfer_req = 1'b1; xfer_reg = 2'(r); wiper_val = 8'(8'hC0 + r * 5);
            @(negedge clk);
            xfer_req = 1'b0;
            end_frame();
            count_busy(n);
            chk(n == PROG, "R8 transfer cycle length", n, PROG);
            mdl[r] = 8'(8'hC0 + r * 5);
            check_all("R8");
        end

        // R9 soft reset mid-cycle keeps contents
        stage_write(14, 8'h11);
        end_frame();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(busy == 1'b0, "R9 busy cleared", busy, 0);
        repeat (PROG + 2) @(negedge clk);
        check_all("R9 contents kept");
        end_frame();
        chk(busy == 1'b0, "R9 staged request cleared", busy, 0);

        // R11 write wins over simultaneous transfer
        @(negedge clk);
        wr_req = 1'b1; wr_bank = 2'd3; wr_reg = 2'd3; wr_data = 8'h42;
        xfer_req = 1'b1; xfer_reg = 2'd0; wiper_val = 8'h24;
        @(negedge clk);
        wr_req = 1'b0; xfer_req = 1'b0;
        end_frame();
        count_busy(n);
        mdl[15] = 8'h42;
        check_all("R11");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule